// File: doc/BRIEF.md
# ADC conversion timing controller

This block paces a successive-approximation analog-to-digital converter from the system clock. A 7-bit prescaler, held cleared while the converter is switched off, provides a one-cycle ADC clock tick and a mid-period phase marker. A select code picks one of seven power-of-two divisions. A conversion state machine counts ADC clock periods from the tick on which a pending start request is taken. It emits a sample-and-hold strobe at the half-period point, then one approximation strobe for each result bit. At the end of the conversion it latches the result word supplied by the analog front end.

A pending start request is recorded when `start_i` is pulsed. The first conversion after enabling is a long one, used for settling. Every later conversion is short. In single mode the pending request is dropped when the conversion completes. In free-running mode the next conversion begins on the completing tick and the request stays pending. A sticky completion flag records each finished conversion until software clears it. Pulling enable low aborts any conversion in progress.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The ADC clock period is 2^max(psel_i,1) system cycles, so codes 0 and 1 both divide by 2. The prescaler counts from zero starting with the first cycle in which en_i is high.
- R2: A start pulse does not begin a conversion at once. The conversion begins on the next ADC clock tick after the request is registered.
- R3: A normal conversion ends 13 ADC clock periods after its starting tick.
- R4: The first conversion after en_i rises lasts 25 ADC clock periods. With en_i and start_i raised together, done_o appears 26 ADC periods after that cycle.
- R5: sample_o pulses once per conversion. It follows the starting tick by 1.5 ADC periods in a normal conversion and by 13.5 periods in the first conversion after enabling.
- R6: step_o pulses exactly 10 times per conversion, once per ADC tick. The first pulse comes 3 ADC periods after the starting tick, and no step shares a cycle with sample_o or done_o.
- R7: result_o takes the value of res_i only in the cycle where a conversion completes. It holds its value during conversions and across an abort.
- R8: done_o pulses for one cycle and sets flag_o at each completion. flag_o then stays high until flag_clr_i is asserted, and a completion in the same cycle as a clear leaves it set.
- R9: In single mode (free_run_i low), start_q_o drops in the same cycle that done_o and flag_o rise.
- R10: In free-running mode the next normal conversion starts on the completing tick. Completions then repeat every 13 ADC periods while start_q_o stays high.
- R11: While en_i is low, busy_o and start_q_o are cleared and start_i is ignored. The next enable again yields a long first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable; low holds the prescaler cleared and aborts |
| start_i | input | 1 | Start request pulse |
| free_run_i | input | 1 | 1 selects back-to-back conversions |
| psel_i | input | 3 | Prescale code; ADC period = 2^max(code,1) cycles |
| flag_clr_i | input | 1 | Clears the completion flag |
| res_i | input | 10 | Result word from the approximation logic |
| start_q_o | output | 1 | Pending/held start request |
| busy_o | output | 1 | Conversion in progress |
| sample_o | output | 1 | Sample-and-hold strobe |
| step_o | output | 1 | Approximation step strobe |
| done_o | output | 1 | One-cycle completion pulse |
| flag_o | output | 1 | Sticky completion flag |
| result_o | output | 10 | Latched conversion result |

## Verification
The bench sweeps every prescale code and measures the exact latency from enable to the first completion, to the sample strobe and to the first step. A design that ignored the settling conversion, started without waiting for a tick, or mapped code 0 to something other than divide-by-2 would be off by whole ADC periods. It lands a flag clear on the very cycle of a completion, so a design that gave the clear priority would lose that flag. It also aborts mid-conversion and re-enables, so a design that forgot to re-arm the long conversion, or that let an abort disturb the result word or the flag, shows a wrong latency or a wrong value.

// File: rtl/adc_seq_pkg.sv
// adc_seq_pkg: shared types for the ADC conversion timing controller.
// Assumes: nothing beyond a synchronous design on one system clock.
package adc_seq_pkg;

    typedef enum logic [0:0] {
        CV_IDLE = 1'b0,
        CV_RUN  = 1'b1
    } conv_state_t;

endpackage

// File: rtl/adc_prescaler.sv
// adc_prescaler: free-running divider for the ADC clock.
// It produces a one-cycle tick at the end of each ADC period and a one-cycle
// mid marker at the half-period point. Tap code 0 aliases tap 1 (divide by 2).
// Assumes: the counter is cleared whenever en_i is low, so the phase after
// enabling is deterministic.
module adc_prescaler #(
    parameter int PRE_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] psel_i,
    output logic             tick_o,
    output logic             mid_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W:0]   tap_tick;
    logic [PRE_W:0]   tap_mid;
    logic             sel_tick;
    logic             sel_mid;

    // Counter: cleared while disabled, counts every cycle while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!en_i)  cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // One tap per division: tick when the low bits are all ones,
    // mid when they equal half the period minus one.
    for (genvar i = 1; i <= PRE_W; i++) begin : g_tap
        localparam logic [PRE_W-1:0] MIDV = PRE_W'((1 << (i - 1)) - 1);
        assign tap_tick[i] = &cnt_q[i-1:0];
        assign tap_mid[i]  = (cnt_q[i-1:0] == MIDV[i-1:0]);
    end
    assign tap_tick[0] = tap_tick[1];
    assign tap_mid[0]  = tap_mid[1];

    // Tap selection, clamping codes above the counter width to the widest tap.
    always_comb begin
        sel_tick = tap_tick[PRE_W];
        sel_mid  = tap_mid[PRE_W];
        for (int j = 0; j <= PRE_W; j++) begin
            if (int'(psel_i) == j) begin
                sel_tick = tap_tick[j];
                sel_mid  = tap_mid[j];
            end
        end
    end

    assign tick_o = en_i & sel_tick;
    assign mid_o  = en_i & sel_mid;
endmodule

// File: rtl/adc_conv_fsm.sv
// adc_conv_fsm: counts ADC periods of one conversion and raises the
// sample, step and completion events (combinational, one system cycle each).
// Assumes: tick_i and mid_i come from adc_prescaler and never coincide.
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int NORM_CYC  = 13,
    parameter int EXT_CYC   = 25,
    parameter int NORM_SAMP = 1,
    parameter int EXT_SAMP  = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic mid_i,
    input  logic start_q_i,
    input  logic free_run_i,
    output logic busy_o,
    output logic sample_evt_o,
    output logic step_evt_o,
    output logic done_evt_o
);
    localparam int CNT_W = $clog2(EXT_CYC + RES_W + 1);
    localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_CYC - 1);
    localparam logic [CNT_W-1:0] EXT_LAST  = CNT_W'(EXT_CYC - 1);
    localparam logic [CNT_W-1:0] NORM_S    = CNT_W'(NORM_SAMP);
    localparam logic [CNT_W-1:0] EXT_S     = CNT_W'(EXT_SAMP);
    localparam logic [CNT_W-1:0] NBITS     = CNT_W'(RES_W);

    conv_state_t      state_q;
    logic [CNT_W-1:0] cyc_q;
    logic             ext_q;
    logic             first_q;
    logic             last;
    logic [CNT_W-1:0] samp_idx;
    logic [CNT_W-1:0] step_hi;
    logic             running;

    assign running  = (state_q == CV_RUN);
    assign last     = (cyc_q == (ext_q ? EXT_LAST : NORM_LAST));
    assign samp_idx = ext_q ? EXT_S : NORM_S;
    assign step_hi  = samp_idx + NBITS;

    // Event decode for the current ADC period.
    always_comb begin
        done_evt_o   = running & tick_i & last;
        sample_evt_o = running & mid_i & (cyc_q == samp_idx);
        step_evt_o   = running & tick_i & (cyc_q > samp_idx) & (cyc_q <= step_hi);
    end

    // Conversion sequencing: start on tick, count periods, finish or chain.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            state_q <= CV_IDLE;
            cyc_q   <= '0;
            ext_q   <= 1'b0;
            first_q <= 1'b1;
        end else begin
            case (state_q)
                CV_IDLE: begin
                    if (tick_i && start_q_i) begin
                        state_q <= CV_RUN;
                        cyc_q   <= '0;
                        ext_q   <= first_q;
                        first_q <= 1'b0;
                    end
                end
                default: begin
                    if (tick_i) begin
                        if (last) begin
                            cyc_q <= '0;
                            ext_q <= 1'b0;
                            if (!free_run_i) state_q <= CV_IDLE;
                        end else begin
                            cyc_q <= cyc_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o = running;
endmodule

// File: rtl/adc_result_reg.sv
// adc_result_reg: result word, sticky completion flag and done pulse.
// Assumes: done_evt_i is a single-cycle event; completion beats a clear.
module adc_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_evt_i,
    input  logic             clr_i,
    input  logic [RES_W-1:0] res_i,
    output logic [RES_W-1:0] result_o,
    output logic             flag_o,
    output logic             done_o
);
    // Result capture only at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)          result_o <= '0;
        else if (done_evt_i) result_o <= res_i;
    end

    // Sticky flag with set priority, and the registered done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= done_evt_i;
            if (done_evt_i)  flag_o <= 1'b1;
            else if (clr_i)  flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// adc_seq_ctrl: top of the ADC conversion timing controller.
// It ties the prescaler, the conversion sequencer and the result register
// together and owns the start request bit and the registered strobes.
// Assumes: single system clock; the ADC clock exists only as enables.
module adc_seq_ctrl #(
    parameter int PRE_W     = 7,
    parameter int SEL_W     = 3,
    parameter int RES_W     = 10,
    parameter int NORM_CYC  = 13,
    parameter int EXT_CYC   = 25,
    parameter int NORM_SAMP = 1,
    parameter int EXT_SAMP  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             free_run_i,
    input  logic [SEL_W-1:0] psel_i,
    input  logic             flag_clr_i,
    input  logic [RES_W-1:0] res_i,
    output logic             start_q_o,
    output logic             busy_o,
    output logic             sample_o,
    output logic             step_o,
    output logic             done_o,
    output logic             flag_o,
    output logic [RES_W-1:0] result_o
);
    logic tick;
    logic mid;
    logic sample_evt;
    logic step_evt;
    logic done_evt;

    adc_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .psel_i (psel_i),
        .tick_o (tick),
        .mid_o  (mid)
    );

    adc_conv_fsm #(
        .RES_W(RES_W), .NORM_CYC(NORM_CYC), .EXT_CYC(EXT_CYC),
        .NORM_SAMP(NORM_SAMP), .EXT_SAMP(EXT_SAMP)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .tick_i       (tick),
        .mid_i        (mid),
        .start_q_i    (start_q_o),
        .free_run_i   (free_run_i),
        .busy_o       (busy_o),
        .sample_evt_o (sample_evt),
        .step_evt_o   (step_evt),
        .done_evt_o   (done_evt)
    );

    adc_result_reg #(.RES_W(RES_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_evt_i (done_evt),
        .clr_i      (flag_clr_i),
        .res_i      (res_i),
        .result_o   (result_o),
        .flag_o     (flag_o),
        .done_o     (done_o)
    );

    // Start request: set by start_i, dropped by disable or single-mode completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)              start_q_o <= 1'b0;
        else if (start_i)                 start_q_o <= 1'b1;
        else if (done_evt && !free_run_i) start_q_o <= 1'b0;
    end

    // Register the strobes so they leave the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= 1'b0;
            step_o   <= 1'b0;
        end else begin
            sample_o <= sample_evt;
            step_o   <= step_evt;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// adc_seq_ctrl_chk: temporal properties of the controller's ports,
// attached to every adc_seq_ctrl instance by the bind below.
module adc_seq_ctrl_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             flag_clr_i,
    input logic             start_q_o,
    input logic             busy_o,
    input logic             sample_o,
    input logic             step_o,
    input logic             done_o,
    input logic             flag_o,
    input logic [RES_W-1:0] result_o
);
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flag_o);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

    a_r6_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_o, step_o, done_o}));

    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!busy_o && !start_q_o));

    a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || !$past(en_i)));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .flag_clr_i (flag_clr_i),
    .start_q_o  (start_q_o),
    .busy_o     (busy_o),
    .sample_o   (sample_o),
    .step_o     (step_o),
    .done_o     (done_o),
    .flag_o     (flag_o),
    .result_o   (result_o)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       start_i = 1'b0;
    logic       free_run_i = 1'b0;
    logic [2:0] psel_i = 3'd0;
    logic       flag_clr_i = 1'b0;
    logic [9:0] res_i = 10'd0;
    logic       start_q_o, busy_o, sample_o, step_o, done_o, flag_o;
    logic [9:0] result_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct packed {
        logic [2:0]  sel;
        logic [31:0] div;
        logic [9:0]  res;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 32'd2,   10'h155},
        '{3'd1, 32'd2,   10'h2AA},
        '{3'd2, 32'd4,   10'h001},
        '{3'd3, 32'd8,   10'h3FF},
        '{3'd4, 32'd16,  10'h0F0},
        '{3'd5, 32'd32,  10'h30C},
        '{3'd6, 32'd64,  10'h123},
        '{3'd7, 32'd128, 10'h2D4}
    };

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i),
        .free_run_i(free_run_i), .psel_i(psel_i), .flag_clr_i(flag_clr_i),
        .res_i(res_i), .start_q_o(start_q_o), .busy_o(busy_o),
        .sample_o(sample_o), .step_o(step_o), .done_o(done_o),
        .flag_o(flag_o), .result_o(result_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Advance cycle by cycle (sampling at negedge) until done_o, recording events.
    task automatic run_to_done(input int limit, output int t_done, output int t_samp,
                               output int n_samp, output int t_step, output int n_step);
        int n = 0;
        t_done = -1; t_samp = -1; n_samp = 0; t_step = -1; n_step = 0;
        while (t_done < 0 && n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start_i = 1'b0;
            if (sample_o) begin n_samp++; if (t_samp < 0) t_samp = n; end
            if (step_o)   begin n_step++; if (t_step < 0) t_step = n; end
            if (done_o) t_done = n;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int td, ts, ns, tst, nst, dv;
        logic [9:0] held;

        // Reset state.
        repeat (3) @(negedge clk);
        check("R7 reset result", int'(result_o), 0);
        check("R8 reset flag", int'(flag_o), 0);
        check("R11 reset busy", int'(busy_o), 0);
        check("R9 reset start", int'(start_q_o), 0);
        rst_n = 1'b1;

        // Start ignored while disabled.
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        check("R11 start ignored while off", int'(start_q_o), 0);
        check("R11 idle while off", int'(busy_o), 0);

        // Table sweep: each prescale code, long first conversion then a normal one.
        foreach (VECS[i]) begin
            dv = int'(VECS[i].div);
            @(negedge clk);
            en_i = 1'b0; free_run_i = 1'b1; psel_i = VECS[i].sel; res_i = VECS[i].res;
            @(negedge clk);
            en_i = 1'b1; start_i = 1'b1;
            run_to_done(40 * dv + 10, td, ts, ns, tst, nst);
            check("R4 R1 enable to first done", td, 26 * dv);
            check("R5 long sample point", ts, (29 * dv) / 2);
            check("R6 long step count", nst, 10);
            check("R7 result captured", int'(result_o), int'(VECS[i].res));
            run_to_done(20 * dv + 10, td, ts, ns, tst, nst);
            check("R3 R10 done to done", td, 13 * dv);
            check("R5 normal sample point", ts, (3 * dv) / 2);
            check("R5 one sample", ns, 1);
            check("R6 first step", tst, 3 * dv);
            check("R6 step count", nst, 10);
            check("R10 start held", int'(start_q_o), 1);
        end

        // Abort by disabling: result and flag untouched, request dropped.
        held = result_o;
        repeat (5) @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check("R11 abort busy", int'(busy_o), 0);
        check("R11 abort start", int'(start_q_o), 0);
        check("R7 result kept on abort", int'(result_o), int'(held));
        check("R8 flag kept on abort", int'(flag_o), 1);
        flag_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0;
        check("R8 clear", int'(flag_o), 0);

        // Single mode, divide by 4.
        psel_i = 3'd2; free_run_i = 1'b0; res_i = 10'h0A5;
        @(negedge clk);
        en_i = 1'b1; start_i = 1'b1;
        run_to_done(200, td, ts, ns, tst, nst);
        check("R4 single long", td, 104);
        check("R9 start dropped at done", int'(start_q_o), 0);
        check("R8 flag set", int'(flag_o), 1);
        check("R7 single result", int'(result_o), 'h0A5);
        start_i = 1'b1; res_i = 10'h35A;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); @(negedge clk); start_i = 1'b0;
        end
        check("R7 result held mid conversion", int'(result_o), 'h0A5);
        check("R9 busy in single", int'(busy_o), 1);
        run_to_done(200, td, ts, ns, tst, nst);
        check("R2 R3 start waits for tick", td + 20, 56);
        check("R7 new result", int'(result_o), 'h35A);
        check("R9 idle after single", int'(busy_o), 0);

        // Free-running: a clear alone, then a clear in the completion cycle.
        free_run_i = 1'b1; start_i = 1'b1;
        run_to_done(200, td, ts, ns, tst, nst);
        @(negedge clk); flag_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0;
        check("R8 clear alone", int'(flag_o), 0);
        repeat (13 * 4 - 3) @(negedge clk);
        flag_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0;
        check("R8 done on clear cycle", int'(done_o), 1);
        check("R8 set beats clear", int'(flag_o), 1);

        // Abort then re-enable: long conversion is re-armed.
        repeat (10) @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        en_i = 1'b1; start_i = 1'b1;
        run_to_done(200, td, ts, ns, tst, nst);
        check("R11 long re-armed", td, 104);

        summary();
    end
endmodule